// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Sequencer

This block is the clocked control path of a synchronous burst static RAM. On every rising clock edge it samples three chip selects, two address-load strobes, a burst-advance input, a sleep input and the write enables. From these it classifies the cycle as one of six kinds: sleep, deselect, start-read, start-write, burst step or hold. The result drives an address register with a wrapping burst counter in its low bits, a byte-lane writable storage array, and a read data pipeline.

The two load strobes are not symmetric. The processor-side strobe (`cpu_ld_n`) always starts a read. It is ignored while `cs_a_n` is high, so a write after it must come on a later hold or step cycle. The controller-side strobe (`ctl_ld_n`) starts a read or a write at once, depending on the decoded write request. Read data leaves through a one-stage pipeline. The output enable acts without a clock, and data drives only after a read cycle that was not followed by a write, deselect or sleep cycle.

Top module: `burst_sram_seq`

## Requirements
- R1: A cycle with `sleep` low, a load taking effect (`cpu_ld_n` low with `cs_a_n` low, or `ctl_ld_n` low) and the selects not all active (`cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0 is "all active") is a deselect. It writes nothing, clears the active burst, and `rdata_oe` is 0 after that edge.
- R2: When `cs_a_n` is high, `cpu_ld_n` has no effect. The cycle is decided by `ctl_ld_n` and `burst_adv_n` as if `cpu_ld_n` were high.
- R3: With all selects active and `cpu_ld_n` low, the cycle loads `addr` and starts a read, whatever the write enables are. Nothing is written.
- R4: With all selects active, `cpu_ld_n` high and `ctl_ld_n` low, the cycle loads `addr`. It starts a write there if the write decode is active, and a read otherwise.
- R5: The write decode is active when `wr_all_n` is 0, or when `wr_byte_n` is 0 and at least one bit of `lane_sel_n` is 0. On a write, lane i (`wdata[8i+7:8i]`, controlled by `lane_sel_n[i]`) is stored when `wr_all_n` is 0, or when `wr_byte_n` is 0 and `lane_sel_n[i]` is 0. Other lanes keep their contents.
- R6: With both strobes inactive and `burst_adv_n` low during an active burst, the address moves to the next one. The two low bits step +1 modulo 4 and the upper bits are held. The cycle then reads or writes there according to the write decode.
- R7: With both strobes inactive and `burst_adv_n` high during an active burst, the address is held. The cycle writes there if the write decode is active and reads otherwise. This is how a write follows a `cpu_ld_n` read.
- R8: With `sleep` high, all other inputs are ignored. Nothing is written, the burst is ended, and `rdata_oe` is 0 after that edge.
- R9: Data for a read cycle at edge k is on `rdata` after edge k+1. `rdata_oe` is 1 after edge k+1 only if that cycle is not a write, deselect or sleep and `rd_oe_n` is 0. After reset `rdata_oe` is 0.
- R10: `rd_oe_n` acts without a clock. Raising it forces `rdata_oe` to 0 and lowering it restores the pipelined state, both within the same clock period.
- R11: Step and hold cycles with no active burst (after reset, deselect or sleep) do not write and produce no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_a_n | input | 1 | Primary chip select, active low; gates `cpu_ld_n` |
| cs_b | input | 1 | Second chip select, active high |
| cs_c_n | input | 1 | Third chip select, active low |
| sleep | input | 1 | Power-down request; overrides everything |
| cpu_ld_n | input | 1 | Processor-side address load strobe, active low |
| ctl_ld_n | input | 1 | Controller-side address load strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, all lanes, active low |
| wr_byte_n | input | 1 | Byte write qualifier, active low |
| lane_sel_n | input | 2 | Per-lane write enables, active low |
| rd_oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 8 | External word address |
| wdata | input | 16 | Write data, two 8-bit lanes |
| rdata | output | 16 | Pipelined read data |
| rdata_oe | output | 1 | High when `rdata` should drive the bus |

## Verification
The hardest state to reach from the ports is a write that follows a processor-strobe read: a `cpu_ld_n` load with the write enables active must still read, and the next hold cycle with a partial lane mask must then write only one lane at that held address. A directed sequence builds this, with a stale pattern on `wdata` during the load cycle that would show up if the load had written. A second directed burst writes five words from an address with low bits 00, so the fifth wraps onto the first. It then reads back from an unaligned start to show the wrap in both directions. A random phase, with addresses confined to sixteen words and load strobes and selects biased toward activity, then mixes deselects, sleeps and inactive-burst steps with real bursts.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   typedef enum logic [2:0] {
      CYC_SLEEP,
      CYC_DESEL,
      CYC_START_RD,
      CYC_START_WR,
      CYC_STEP,
      CYC_HOLD
   } cyc_e;
endpackage

// File: rtl/bsr_decode.sv
module bsr_decode
   import bsr_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic             cs_a_n,
   input  logic             cs_b,
   input  logic             cs_c_n,
   input  logic             cpu_ld_n,
   input  logic             ctl_ld_n,
   input  logic             burst_adv_n,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             burst_live,
   output cyc_e             cyc,
   output logic             acc_rd,
   output logic             acc_wr,
   output logic [LANES-1:0] lane_we
);
   if (LANES < 1) begin : g_bad_lanes
      $error("bsr_decode: LANES must be at least 1");
   end

   logic             sel_ok;
   logic             wr_req;
   logic [LANES-1:0] lane_mask;
   logic             cont;

   assign sel_ok    = !cs_a_n && cs_b && !cs_c_n;
   assign lane_mask = {LANES{!wr_all_n}} | ({LANES{!wr_byte_n}} & ~lane_sel_n);
   assign wr_req    = |lane_mask;

   always_comb begin
      if (sleep)                       cyc = CYC_SLEEP;
      else if (!cpu_ld_n && !cs_a_n)   cyc = sel_ok ? CYC_START_RD : CYC_DESEL;
      else if (!ctl_ld_n)              cyc = !sel_ok ? CYC_DESEL :
                                             (wr_req ? CYC_START_WR : CYC_START_RD);
      else if (!burst_adv_n)           cyc = CYC_STEP;
      else                             cyc = CYC_HOLD;
   end

   assign cont    = (cyc == CYC_STEP) || (cyc == CYC_HOLD);
   assign acc_wr  = (cyc == CYC_START_WR) || (cont && burst_live && wr_req);
   assign acc_rd  = (cyc == CYC_START_RD) || (cont && burst_live && !wr_req);
   assign lane_we = acc_wr ? lane_mask : '0;

   // R3
   cpu_ld_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !cpu_ld_n && !cs_a_n) |-> (lane_we == '0));
   // R1
   desel_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_DESEL) |-> (lane_we == '0 && !acc_rd));
   // R11
   idle_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cont && !burst_live) |-> (!acc_rd && !acc_wr));
   // R8
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (lane_we == '0 && !acc_rd));
endmodule

// File: rtl/bsr_addr_ctr.sv
module bsr_addr_ctr #(
   parameter int ADDR_W  = 8,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] eff_addr
);
   if (BURST_W < 1 || BURST_W > ADDR_W) begin : g_bad_burst
      $error("bsr_addr_ctr: BURST_W must lie in 1..ADDR_W");
   end

   localparam logic [BURST_W-1:0] ONE_B = 1;

   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] stepped;

   if (BURST_W == ADDR_W) begin : g_full
      assign stepped = cur_q + ADDR_W'(1);
   end else begin : g_split
      assign stepped = {cur_q[ADDR_W-1:BURST_W], cur_q[BURST_W-1:0] + ONE_B};

      // R6
      upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (step && !load) |=> $stable(cur_q[ADDR_W-1:BURST_W]));
   end

   assign eff_addr = load ? ext_addr : (step ? stepped : cur_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= eff_addr;
   end

   // R6
   burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cur_q[BURST_W-1:0] == $past(cur_q[BURST_W-1:0]) + ONE_B));
   // R7
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(cur_q));
endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                      clk,
   input  logic [LANES-1:0]          lane_we,
   input  logic [ADDR_W-1:0]         acc_addr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic                      rd_en,
   output logic [LANES*LANE_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_depth
      $error("bsr_array: ADDR_W must lie in 1..12");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("bsr_array: LANE_W must be at least 1");
   end

   logic [ADDR_W-1:0] rd_addr_q;

   always_ff @(posedge clk) begin
      if (rd_en) rd_addr_q <= acc_addr;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      logic [LANE_W-1:0] q;

      always_ff @(posedge clk) begin
         if (lane_we[g]) store[acc_addr] <= wdata[g*LANE_W +: LANE_W];
         q <= store[rd_addr_q];
      end

      assign rdata[g*LANE_W +: LANE_W] = q;
   end
endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
   import bsr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int LANES   = 2,
   parameter int LANE_W  = 8,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_a_n,
   input  logic                    cs_b,
   input  logic                    cs_c_n,
   input  logic                    sleep,
   input  logic                    cpu_ld_n,
   input  logic                    ctl_ld_n,
   input  logic                    burst_adv_n,
   input  logic                    wr_all_n,
   input  logic                    wr_byte_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    rd_oe_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);
   localparam int DATA_W = LANES * LANE_W;

   if (DATA_W > 1024) begin : g_bad_width
      $error("burst_sram_seq: data path too wide");
   end

   cyc_e              cyc;
   logic              acc_rd;
   logic              acc_wr;
   logic [LANES-1:0]  lane_we;
   logic              live_q;
   logic              rd1_q;
   logic              outv_q;
   logic              load;
   logic              step;
   logic              kill;
   logic [ADDR_W-1:0] eff_addr;

   bsr_decode #(.LANES(LANES)) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep       (sleep),
      .cs_a_n      (cs_a_n),
      .cs_b        (cs_b),
      .cs_c_n      (cs_c_n),
      .cpu_ld_n    (cpu_ld_n),
      .ctl_ld_n    (ctl_ld_n),
      .burst_adv_n (burst_adv_n),
      .wr_all_n    (wr_all_n),
      .wr_byte_n   (wr_byte_n),
      .lane_sel_n  (lane_sel_n),
      .burst_live  (live_q),
      .cyc         (cyc),
      .acc_rd      (acc_rd),
      .acc_wr      (acc_wr),
      .lane_we     (lane_we)
   );

   assign load = (cyc == CYC_START_RD) || (cyc == CYC_START_WR);
   assign step = (cyc == CYC_STEP) && live_q;
   assign kill = acc_wr || (cyc == CYC_DESEL) || (cyc == CYC_SLEEP);

   bsr_addr_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .ext_addr (addr),
      .eff_addr (eff_addr)
   );

   bsr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk      (clk),
      .lane_we  (lane_we),
      .acc_addr (eff_addr),
      .wdata    (wdata),
      .rd_en    (acc_rd),
      .rdata    (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         rd1_q  <= 1'b0;
         outv_q <= 1'b0;
      end else begin
         if (load)                                        live_q <= 1'b1;
         else if ((cyc == CYC_DESEL) || (cyc == CYC_SLEEP)) live_q <= 1'b0;
         rd1_q  <= acc_rd;
         outv_q <= rd1_q && !kill;
      end
   end

   assign rdata_oe = outv_q && !rd_oe_n;

   // R8
   sleep_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (!outv_q && !live_q));
   // R1
   desel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_DESEL) |=> (!outv_q && !live_q));
   // R9
   write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_we != '0) |=> !outv_q);
   // R9
   rd_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(outv_q) |-> $past(rd1_q));
endmodule

// File: tb/sim_burst_sram_seq.sv
module sim_burst_sram_seq;
   localparam int CLK_PERIOD = 10;
   localparam int K_SLEEP = 0, K_DESEL = 1, K_SRD = 2, K_SWR = 3, K_STEP = 4, K_HOLD = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_a_n, cs_b, cs_c_n, sleep, cpu_ld_n, ctl_ld_n, burst_adv_n;
   logic        wr_all_n, wr_byte_n, rd_oe_n;
   logic [1:0]  lane_sel_n;
   logic [7:0]  addr;
   logic [15:0] wdata;
   logic [15:0] rdata;
   logic        rdata_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model state
   bit         m_live, m_rd1, m_outv;
   logic [7:0] m_addr, m_rdaddr;
   logic [15:0] m_mem [256];
   bit [1:0]   m_known [256];
   logic [15:0] m_outd;
   bit [1:0]   m_outk;

   burst_sram_seq u0 (
      .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
      .sleep(sleep), .cpu_ld_n(cpu_ld_n), .ctl_ld_n(ctl_ld_n),
      .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
      .lane_sel_n(lane_sel_n), .rd_oe_n(rd_oe_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete (actual hung, expected done)");
         finish_run();
      end
   end

   function automatic int kind_of();
      bit sel_ok;
      bit wrq;
      sel_ok = !cs_a_n && cs_b && !cs_c_n;
      wrq = !wr_all_n || (!wr_byte_n && (lane_sel_n != 2'b11));
      if (sleep) return K_SLEEP;
      if (!cpu_ld_n && !cs_a_n) return sel_ok ? K_SRD : K_DESEL;
      if (!ctl_ld_n) return !sel_ok ? K_DESEL : (wrq ? K_SWR : K_SRD);
      if (!burst_adv_n) return K_STEP;
      return K_HOLD;
   endfunction

   task automatic model_step();
      int k;
      bit wrq, do_wr, do_rd;
      bit [1:0] mask;
      logic [7:0] eff;
      k = kind_of();
      mask = {2{!wr_all_n}} | ({2{!wr_byte_n}} & ~lane_sel_n);
      wrq = (mask != 2'b00);
      do_wr = (k == K_SWR) || ((k == K_STEP || k == K_HOLD) && m_live && wrq);
      do_rd = (k == K_SRD) || ((k == K_STEP || k == K_HOLD) && m_live && !wrq);
      if (k == K_SRD || k == K_SWR) eff = addr;
      else if (k == K_STEP && m_live) eff = {m_addr[7:2], m_addr[1:0] + 2'd1};
      else eff = m_addr;
      m_outv = m_rd1 && !(do_wr || k == K_DESEL || k == K_SLEEP);
      m_outd = m_mem[m_rdaddr];
      m_outk = m_known[m_rdaddr];
      m_rd1 = do_rd;
      if (do_rd) m_rdaddr = eff;
      if (do_wr) begin
         for (int i = 0; i < 2; i++) begin
            if (mask[i]) begin
               m_mem[eff][i*8 +: 8] = wdata[i*8 +: 8];
               m_known[eff][i] = 1'b1;
            end
         end
      end
      m_addr = eff;
      if (k == K_SRD || k == K_SWR) m_live = 1;
      else if (k == K_DESEL || k == K_SLEEP) m_live = 0;
   endtask

   task automatic compare(input string tag);
      bit exp_en;
      exp_en = m_outv && !rd_oe_n;
      n_chk++;
      if (rdata_oe !== exp_en) begin
         n_bad++;
         $display("FAIL %s: rdata_oe actual %0b expected %0b", tag, rdata_oe, exp_en);
      end
      if (exp_en) begin
         for (int i = 0; i < 2; i++) begin
            if (m_outk[i]) begin
               n_chk++;
               if (rdata[i*8 +: 8] !== m_outd[i*8 +: 8]) begin
                  n_bad++;
                  $display("FAIL %s: rdata lane %0d actual %h expected %h",
                           tag, i, rdata[i*8 +: 8], m_outd[i*8 +: 8]);
               end
            end
         end
      end
   endtask

   task automatic cyc(input string tag);
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle();
      cs_a_n = 0; cs_b = 1; cs_c_n = 0; sleep = 0;
      cpu_ld_n = 1; ctl_ld_n = 1; burst_adv_n = 1;
      wr_all_n = 1; wr_byte_n = 1; lane_sel_n = 2'b11; rd_oe_n = 0;
   endtask

   task automatic check_val(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   initial begin
      void'($urandom(32'd7741));
      for (int i = 0; i < 256; i++) begin m_mem[i] = '0; m_known[i] = 2'b00; end
      m_live = 0; m_rd1 = 0; m_outv = 0; m_addr = '0; m_rdaddr = '0;
      m_outd = '0; m_outk = 2'b00;
      idle(); addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      check_val("R9 reset", rdata_oe, 1'b0);
      rst_n = 1;
      @(negedge clk);
      compare("R9");

      // R4 start write at 0x10 via controller strobe
      idle(); ctl_ld_n = 0; wr_all_n = 0; addr = 8'h10; wdata = 16'h1234; cyc("R4");
      // R3 processor strobe reads despite write enables, stale data on wdata
      idle(); cpu_ld_n = 0; wr_all_n = 0; addr = 8'h10; wdata = 16'hBEEF; cyc("R3");
      idle(); cyc("R3");
      // R7 hold-write of lane 0 only, following the processor-strobe read
      idle(); wr_byte_n = 0; lane_sel_n = 2'b10; wdata = 16'h55AA; cyc("R7");
      idle(); cyc("R7");
      idle(); cyc("R7");
      idle(); cyc("R7");
      // R5 byte qualifier high: lanes low but no write, becomes a read
      idle(); ctl_ld_n = 0; lane_sel_n = 2'b00; addr = 8'h10; wdata = 16'hFFFF; cyc("R5");
      idle(); cyc("R5");
      // R5 lane 1 only
      idle(); ctl_ld_n = 0; wr_byte_n = 0; lane_sel_n = 2'b01; addr = 8'h10; wdata = 16'h9900; cyc("R5");
      idle(); ctl_ld_n = 0; addr = 8'h10; cyc("R5");
      idle(); cyc("R5");
      idle(); cyc("R5");

      // R6 burst write of five words from 0x20, fifth wraps to 0x20
      idle(); ctl_ld_n = 0; wr_all_n = 0; addr = 8'h20; wdata = 16'hA000; cyc("R6");
      for (int i = 1; i < 5; i++) begin
         idle(); burst_adv_n = 0; wr_all_n = 0; wdata = 16'hA000 + 16'(i); cyc("R6");
      end
      // R6 burst read from 0x23 wrapping through 0x20
      idle(); ctl_ld_n = 0; addr = 8'h23; cyc("R6");
      for (int i = 0; i < 3; i++) begin
         idle(); burst_adv_n = 0; cyc("R6");
      end
      // R2 processor strobe with cs_a_n high is ignored: step continues
      idle(); cs_a_n = 1; cpu_ld_n = 0; burst_adv_n = 0; addr = 8'h00; cyc("R2");
      idle(); cs_a_n = 1; cpu_ld_n = 0; burst_adv_n = 0; addr = 8'h00; cyc("R2");

      // R10 asynchronous output enable
      rd_oe_n = 1; #1;
      check_val("R10", rdata_oe, 1'b0);
      rd_oe_n = 0; #1;
      check_val("R10", rdata_oe, m_outv);

      // R1 deselect with write request
      idle(); ctl_ld_n = 0; cs_b = 0; wr_all_n = 0; addr = 8'h20; wdata = 16'hDEAD; cyc("R1");
      check_val("R1", rdata_oe, 1'b0);
      // R11 inactive-burst steps and holds with write enables
      idle(); burst_adv_n = 0; wr_all_n = 0; wdata = 16'hDEAD; cyc("R11");
      idle(); wr_all_n = 0; wdata = 16'hDEAD; cyc("R11");
      idle(); cyc("R11");
      idle(); ctl_ld_n = 0; addr = 8'h21; cyc("R11");
      idle(); cyc("R11");
      idle(); cyc("R11");

      // R8 sleep ignores a write request and ends the burst
      idle(); ctl_ld_n = 0; addr = 8'h20; cyc("R8");
      idle(); sleep = 1; ctl_ld_n = 0; wr_all_n = 0; addr = 8'h20; wdata = 16'hC0DE; cyc("R8");
      check_val("R8", rdata_oe, 1'b0);
      idle(); wr_all_n = 0; wdata = 16'hC0DE; cyc("R8");
      idle(); ctl_ld_n = 0; addr = 8'h20; cyc("R8");
      idle(); cyc("R8");
      idle(); cyc("R8");

      // random phase
      for (int v = 0; v < 4000; v++) begin
         sleep       = ($urandom % 40) == 0;
         cs_a_n      = ($urandom % 8) == 0;
         cs_b        = ($urandom % 8) != 0;
         cs_c_n      = ($urandom % 8) == 0;
         cpu_ld_n    = ($urandom % 5) != 0;
         ctl_ld_n    = ($urandom % 4) != 0;
         burst_adv_n = 1'($urandom);
         wr_all_n    = ($urandom % 4) != 0;
         wr_byte_n   = 1'($urandom);
         lane_sel_n  = 2'($urandom);
         rd_oe_n     = ($urandom % 6) == 0;
         addr        = 8'h80 | 8'($urandom % 16);
         wdata       = 16'($urandom);
         cyc("R9");
      end

      done = 1;
      finish_run();
   end
endmodule